// File: doc/BRIEF.md
# Dual-Rail Handshaked Two-Input Logic Cell

This cell takes two Boolean tokens and produces one result token. Each token uses two wires: one for true and one for false. Each link uses a four-phase acknowledge handshake. A static parameter sets the function to AND, NAND, OR, NOR or XOR. A second parameter sets one or two downstream receivers. The model is a synchronous RTL emulation: one clock samples all rails and acknowledge lines.

The AND family works as one AND datapath, with the rails swapped at the inputs, the output, or both, following De Morgan's laws. When one input already holds the controlling value, the cell may emit its result before the other token arrives. It still waits for both tokens before it acknowledges either one. XOR always waits for both tokens. An input with both rails high is a fault. The cell then sets a sticky error flag and freezes until reset.

Top module: `dr_logic_cell`

## Requirements
- R1: On every link, a token is true when only the true rail is high and false when only the false rail is high. Both rails low means empty. The cell never drives both output rails high.
- R2: The cell places a result only when its output rails are empty and every receiver acknowledge is high. It holds the result unchanged until every receiver acknowledge is low, and then returns the output rails to empty.
- R3: Early output. With FUNC 0 (AND) or 1 (NAND), a false token on one input produces the result before the other input arrives. With FUNC 2 (OR) or 3 (NOR), a true token on one input does the same. A non-controlling value on one input produces nothing until the other input arrives.
- R4: Input acknowledge rules:
  - An input acknowledge is high when the cell can take a new token.
  - Both input acknowledges drop in the same cycle, and only after the result for the current pair has been produced and both tokens are present.
  - Each acknowledge rises again once its input rails are empty.
- R5: The result equals the function selected by FUNC applied to the two input values: 0 AND, 1 NAND, 2 OR, 3 NOR, 4 XOR.
- R6: With FUNC 4 (XOR), no result appears until both input tokens are present.
- R7: With FANOUT 2, the result stays on the output rails while either receiver acknowledge is still high.
- R8: Exactly one result token is produced for each input pair, including a pair whose result was produced early.
- R9: An input with both rails high sets the error output. The error output then stays set, and the cell changes no output or acknowledge until reset.
- R10: After reset, both input acknowledges are high, the output rails are empty, and the error output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_t | input | 1 | Input A true rail |
| a_f | input | 1 | Input A false rail |
| a_ack | output | 1 | Input A acknowledge (high = ready) |
| b_t | input | 1 | Input B true rail |
| b_f | input | 1 | Input B false rail |
| b_ack | output | 1 | Input B acknowledge (high = ready) |
| y_t | output | 1 | Result true rail |
| y_f | output | 1 | Result false rail |
| y_ack | input | FANOUT | Receiver acknowledges, one per receiver |
| err | output | 1 | Sticky illegal-input flag |

## Verification
Five cells, one per function, share the input links. Each one is drained by a receiver with random delays, and inputs arrive in a random order with random gaps.

Directed probes place one input and hold the other back, to test early output:
- A cell that fires early on the wrong value, or not at all, shows a wrong token count while the second input is still absent.
- A cell that acknowledges on its early result alone drops an input acknowledge too soon.
- A cell without the early-output flag emits a second token when the late input arrives. The per-lane count and the scoreboard catch this.

With two receivers, the bench drops the first acknowledge and then checks that the result has not been withdrawn before the second one drops. An illegal input must latch the error output and freeze the cell.

// File: rtl/dr_logic_cell.sv
module dr_logic_cell #(
  parameter int FUNC   = 0,
  parameter int FANOUT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_t,
  input  logic              a_f,
  output logic              a_ack,
  input  logic              b_t,
  input  logic              b_f,
  output logic              b_ack,
  output logic              y_t,
  output logic              y_f,
  input  logic [FANOUT-1:0] y_ack,
  output logic              err
);
  localparam bit IS_XOR  = (FUNC == 4);
  localparam bit SWAP_IN = (FUNC == 2) || (FUNC == 3);
  localparam bit INV_OUT = (FUNC == 1) || (FUNC == 2);

  logic a_lo, b_lo, fired, yt_q, yf_q, err_q;

  logic a_in, b_in, pa_t, pa_f, pb_t, pb_f;
  assign a_in = (a_t ^ a_f) & ~a_lo;
  assign b_in = (b_t ^ b_f) & ~b_lo;
  assign pa_t = SWAP_IN ? a_f : a_t;
  assign pa_f = SWAP_IN ? a_t : a_f;
  assign pb_t = SWAP_IN ? b_f : b_t;
  assign pb_f = SWAP_IN ? b_t : b_f;

  logic and_f, and_t, go, val;
  assign and_f = (a_in & pa_f) | (b_in & pb_f);
  assign and_t = a_in & b_in & pa_t & pb_t;

  generate
    if (IS_XOR) begin : g_xor
      assign go  = a_in & b_in;
      assign val = a_t ^ b_t;
    end else begin : g_and
      assign go  = and_f | and_t;
      assign val = and_t ^ INV_OUT;
    end
  endgenerate

  logic y_empty, emit, drained, take, bad;
  assign y_empty = ~yt_q & ~yf_q;
  assign emit    = ~fired & go & y_empty & (&y_ack);
  assign drained = ~y_empty & ~(|y_ack);
  assign take    = fired & a_in & b_in;
  assign bad     = (a_t & a_f) | (b_t & b_f);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_lo <= 1'b0; b_lo <= 1'b0; fired <= 1'b0;
      yt_q <= 1'b0; yf_q <= 1'b0; err_q <= 1'b0;
    end else if (!err_q) begin
      if (bad) begin
        err_q <= 1'b1;
      end else begin
        if (emit) begin
          yt_q  <= val;
          yf_q  <= ~val;
          fired <= 1'b1;
        end else if (drained) begin
          yt_q <= 1'b0;
          yf_q <= 1'b0;
        end
        if (take) begin
          fired <= 1'b0;
          a_lo  <= 1'b1;
          b_lo  <= 1'b1;
        end
        if (a_lo && !a_t && !a_f) a_lo <= 1'b0;
        if (b_lo && !b_t && !b_f) b_lo <= 1'b0;
      end
    end
  end

  assign a_ack = ~a_lo;
  assign b_ack = ~b_lo;
  assign y_t   = yt_q;
  assign y_f   = yf_q;
  assign err   = err_q;

  p_legal_out_r1: assert property (@(posedge clk) disable iff (!rst_n) !(y_t && y_f));
  p_emit_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(y_t || y_f) |-> $past(&y_ack));
  p_hold_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((y_t || y_f) && (|y_ack)) |=> $stable({y_t, y_f}));
  p_ack_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(a_ack) |-> ($fell(b_ack) && $past(b_t || b_f) && $past(a_t || a_f)));
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> (err && $stable({y_t, y_f, a_ack, b_ack})));
  generate
    if (IS_XOR) begin : g_xor_chk
      p_xor_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(y_t || y_f) |-> $past((a_t || a_f) && (b_t || b_f)));
    end
  endgenerate
endmodule

// File: tb/sim_dr_logic_cell.sv
module sim_dr_logic_cell;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic at = 1'b0, af = 1'b0, bt = 1'b0, bf = 1'b0;
  logic [4:0] aack, back, yt, yf, er;
  logic [1:0] yk [5];

  dr_logic_cell #(.FUNC(0), .FANOUT(2)) u0 (.clk(clk), .rst_n(rst_n), .a_t(at), .a_f(af), .a_ack(aack[0]),
    .b_t(bt), .b_f(bf), .b_ack(back[0]), .y_t(yt[0]), .y_f(yf[0]), .y_ack(yk[0]), .err(er[0]));
  dr_logic_cell #(.FUNC(1), .FANOUT(1)) u1 (.clk(clk), .rst_n(rst_n), .a_t(at), .a_f(af), .a_ack(aack[1]),
    .b_t(bt), .b_f(bf), .b_ack(back[1]), .y_t(yt[1]), .y_f(yf[1]), .y_ack(yk[1][0:0]), .err(er[1]));
  dr_logic_cell #(.FUNC(2), .FANOUT(1)) u2 (.clk(clk), .rst_n(rst_n), .a_t(at), .a_f(af), .a_ack(aack[2]),
    .b_t(bt), .b_f(bf), .b_ack(back[2]), .y_t(yt[2]), .y_f(yf[2]), .y_ack(yk[2][0:0]), .err(er[2]));
  dr_logic_cell #(.FUNC(3), .FANOUT(1)) u3 (.clk(clk), .rst_n(rst_n), .a_t(at), .a_f(af), .a_ack(aack[3]),
    .b_t(bt), .b_f(bf), .b_ack(back[3]), .y_t(yt[3]), .y_f(yf[3]), .y_ack(yk[3][0:0]), .err(er[3]));
  dr_logic_cell #(.FUNC(4), .FANOUT(1)) u4 (.clk(clk), .rst_n(rst_n), .a_t(at), .a_f(af), .a_ack(aack[4]),
    .b_t(bt), .b_f(bf), .b_ack(back[4]), .y_t(yt[4]), .y_f(yf[4]), .y_ack(yk[4][0:0]), .err(er[4]));

  int nchk = 0, nerr = 0, npairs = 0;
  int cnt [5];
  bit q [5][$];
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit fref(input int k, input bit a, input bit b);
    case (k)
      0: return a & b;
      1: return ~(a & b);
      2: return a | b;
      3: return ~(a | b);
      default: return a ^ b;
    endcase
  endfunction

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  // receiver / monitor for lane k
  task automatic recv(input int k);
    forever begin
      @(negedge clk);
      if (yt[k] && yf[k]) chk(0, "R1 legal output", 3, 1);
      if (yk[k] == 2'b11 && (yt[k] || yf[k])) begin
        bit got = yt[k];
        cnt[k]++;
        if (q[k].size() == 0) chk(0, "R8 unexpected token", cnt[k], npairs);
        else begin
          bit e = q[k].pop_front();
          chk(got == e, "R5 function value", got, e);
        end
        repeat ($urandom_range(0, 3)) @(negedge clk);
        if (k == 0) begin
          yk[0][0] = 1'b0;
          repeat (2) @(negedge clk);
          chk(yt[0] == got && yf[0] == !got, "R7 held for second receiver", yt[0], got);
          yk[0][1] = 1'b0;
        end else yk[k] = 2'b00;
        while (yt[k] || yf[k]) @(negedge clk);
        repeat ($urandom_range(0, 3)) @(negedge clk);
        yk[k] = 2'b11;
      end
    end
  endtask

  task automatic wait_ready();
    while (!(&aack) || !(&back)) @(negedge clk);
  endtask

  task automatic push_exp(input bit a, input bit b);
    for (int k = 0; k < 5; k++) q[k].push_back(fref(k, a, b));
    npairs++;
  endtask

  task automatic send_a(input bit v, input int d);
    repeat (d) @(negedge clk);
    at = v; af = !v;
    while (|aack) @(negedge clk);
    at = 1'b0; af = 1'b0;
  endtask

  task automatic send_b(input bit v, input int d);
    repeat (d) @(negedge clk);
    bt = v; bf = !v;
    while (|back) @(negedge clk);
    bt = 1'b0; bf = 1'b0;
  endtask

  task automatic pair(input bit a, input bit b, input int da, input int db);
    wait_ready();
    push_exp(a, b);
    fork
      send_a(a, da);
      send_b(b, db);
    join
  endtask

  // R3/R6/R4: present A only, hold B back, check which lanes fired
  task automatic probe(input bit a);
    int c0 [5];
    wait_ready();
    push_exp(a, 1'b1);
    for (int k = 0; k < 5; k++) c0[k] = cnt[k];
    at = a; af = !a;
    repeat (10) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      int e = ((k < 2) == (a == 1'b0)) ? 1 : 0;
      chk(cnt[k] - c0[k] == e, "R3 early output", cnt[k] - c0[k], e);
    end
    chk(cnt[4] == c0[4], "R6 xor waits", cnt[4] - c0[4], 0);
    chk(aack == 5'b11111, "R4 no ack before both tokens", aack, 31);
    fork
      begin
        while (|aack) @(negedge clk);
        at = 1'b0; af = 1'b0;
      end
      send_b(1'b1, 0);
    join
  endtask

  initial begin
    for (int k = 0; k < 5; k++) begin yk[k] = 2'b11; cnt[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(aack == 5'b11111 && back == 5'b11111, "R10 acks high", aack, 31);
    chk(yt == 0 && yf == 0, "R10 outputs empty", yt | yf, 0);
    chk(er == 0, "R10 no error", er, 0);
    for (int k = 0; k < 5; k++) fork
      automatic int kk = k;
      recv(kk);
    join_none
    probe(1'b0);
    probe(1'b1);
    for (int i = 0; i < 4; i++) pair(i[1], i[0], 0, 0);
    for (int i = 0; i < 300; i++)
      pair($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 5), $urandom_range(0, 5));
    wait_ready();
    repeat (20) @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      chk(cnt[k] == npairs, "R8 one token per pair", cnt[k], npairs);
      chk(q[k].size() == 0, "R8 no missing token", q[k].size(), 0);
    end
    at = 1'b1; af = 1'b1;
    repeat (3) @(negedge clk);
    chk(er == 5'b11111, "R9 error raised", er, 31);
    at = 1'b0; af = 1'b0;
    bt = 1'b1; bf = 1'b0;
    repeat (10) @(negedge clk);
    chk(er == 5'b11111, "R9 error sticky", er, 31);
    chk(yt == 0 && yf == 0 && aack == 5'b11111 && back == 5'b11111, "R9 frozen", yt | yf, 0);
    finish_up();
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_up();
  end
endmodule